// File: doc/BRIEF.md
# Multi-lane receive byte unpacker

This block sits at the receiving end of a synchronous bus with four 8-bit byte lanes clocked by one receive clock. In every cycle the sender may mark any subset of the lanes as carrying a frame byte. For each such byte it also gives a payload flag and four frame-marker flags. The block captures the marked lanes and drops the unmarked ones. It packs the remaining bytes in bus order, highest-numbered lane first, and hands them out one byte per clock. Each byte carries its own payload and marker flags.

Up to four bytes can arrive per clock, but only one leaves. A banked FIFO therefore absorbs bursts. Each bank is a simple one-write, one-read memory, so block RAM can be used. The sender gets no backpressure. When a cycle's bytes do not fit in the free space, that whole group is discarded and a sticky overflow flag is raised. The consumer reads a plain valid/data stream. It simply takes every byte shown while the output valid is high.

Top module: `rx_lane_unpacker`

## Requirements
- R1: Lane N is carried on `in_data[8N+7:8N]` and is qualified by bit N of `in_val`. The bytes of one input cycle leave in decreasing lane order, so lane 3 comes first.
- R2: Any pattern of set `in_val` bits is accepted, contiguous or not. Unflagged lanes produce no output byte, and the flagged ones are compacted without gaps. For example, pattern 1011 yields lane 3, then lane 1, then lane 0.
- R3: A cycle with `in_val` all zero produces no output byte. In such a cycle the data and flag inputs have no effect.
- R4: `out_pay` equals the `in_pay` bit of the lane the byte came from. A flagged lane with `in_pay` low is still forwarded, with `out_pay` low.
- R5: `out_mark` carries the source lane's marker bits in this order: bit 3 fixed frame position, bit 2 embedded frame position, bit 1 fixed overhead, bit 0 embedded overhead. Marker bits of unflagged lanes never appear.
- R6: A full four-lane word is accepted on every clock. While the FIFO holds data, one byte leaves per clock with no idle cycle between bytes.
- R7: From an empty block, the first byte of a word captured at a rising edge appears on the output after the third rising edge that follows.
- R8: The FIFO holds 16 bytes. A cycle's group of bytes is accepted only if its size is at most 16 minus the occupancy at that edge. Otherwise the whole group is dropped and `overflow` is set, and `overflow` stays set until reset.
- R9: A synchronous active-high `rst` empties the FIFO and clears `out_valid`, the output fields and `overflow`.
- R10: While `out_valid` is low, `out_data`, `out_pay` and `out_mark` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_val | input | 4 | Per-lane frame byte present |
| in_pay | input | 4 | Per-lane payload byte flag |
| in_fixpos | input | 4 | Per-lane fixed frame position marker |
| in_embpos | input | 4 | Per-lane embedded frame position marker |
| in_fixoh | input | 4 | Per-lane fixed overhead marker |
| in_emboh | input | 4 | Per-lane embedded overhead marker |
| in_data | input | 32 | Lane data, lane N at bits [8N+7:8N] |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_pay | output | 1 | Output byte is payload |
| out_mark | output | 4 | Output byte markers {fixpos, embpos, fixoh, emboh} |
| overflow | output | 1 | Sticky: an input group was dropped |

## Verification
Several properties are checked on every cycle: zeroed outputs when invalid, a stuck overflow flag, the occupancy bound, the reset result, and the fixed delay from a captured word or a non-empty FIFO to an output byte. Only the directed scenarios can show that bytes leave in the right lane order with the right flags. The same holds for sparse patterns being compacted, idle-cycle data being ignored, and overflow dropping exactly the groups that did not fit while keeping the others whole.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  localparam int BYTE_W = 8;
  localparam int MARK_W = 4;

  // mark bit order: [3] fixed frame pos, [2] embedded frame pos,
  // [1] fixed overhead, [0] embedded overhead
  typedef struct packed {
    logic              pay;
    logic [MARK_W-1:0] mark;
    logic [BYTE_W-1:0] data;
  } rxu_ent_t;
endpackage

// File: rtl/rxu_capture.sv
module rxu_capture
  import rxu_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        in_val,
  input  logic [LANES-1:0]        in_pay,
  input  logic [LANES-1:0]        in_fixpos,
  input  logic [LANES-1:0]        in_embpos,
  input  logic [LANES-1:0]        in_fixoh,
  input  logic [LANES-1:0]        in_emboh,
  input  logic [LANES*BYTE_W-1:0] in_data,
  output logic [LANES-1:0]        cap_val,
  output rxu_ent_t [LANES-1:0]    cap_lane
);
  always_ff @(posedge clk) begin
    if (rst) cap_val <= '0;
    else     cap_val <= in_val;
  end

  // lane contents carry no reset: they are qualified by cap_val
  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES; g++) begin
      cap_lane[g].data <= in_data[g*BYTE_W +: BYTE_W];
      cap_lane[g].pay  <= in_pay[g];
      cap_lane[g].mark <= {in_fixpos[g], in_embpos[g], in_fixoh[g], in_emboh[g]};
    end
  end
endmodule

// File: rtl/rxu_compact.sv
module rxu_compact
  import rxu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]     cap_val,
  input  rxu_ent_t [LANES-1:0] cap_lane,
  output rxu_ent_t [LANES-1:0] slot,
  output logic [CNT_W-1:0]     cnt
);
  logic [LANES-1:0][CNT_W-1:0] rank;

  // rank of a lane = number of flagged lanes above it
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      rank[l] = acc;
      acc     = acc + CNT_W'(cap_val[l]);
    end
    cnt = acc;
  end

  // slot k takes the flagged lane whose rank is k
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      slot[k] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (cap_val[l] && rank[l] == CNT_W'(k)) slot[k] = cap_lane[l];
      end
    end
  end
endmodule

// File: rtl/rxu_bank_fifo.sv
module rxu_bank_fifo
  import rxu_pkg::*;
#(
  parameter int LANES = 4,   // power of two, at least 2
  parameter int DEPTH = 16,  // power of two, multiple of LANES, at least 2*LANES
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int BANK_W = $clog2(LANES),
  localparam int ROWS   = DEPTH / LANES,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     wr_cnt,
  input  rxu_ent_t [LANES-1:0] wr_slot,
  output logic                 rd_valid,
  output rxu_ent_t             rd_ent,
  output logic [LVL_W-1:0]     level,
  output logic                 ovf
);
  logic [PTR_W-1:0]      wptr, rptr;
  logic                  fits, do_wr, do_rd;
  logic [BANK_W-1:0]     sel_q;
  rxu_ent_t [LANES-1:0]  bank_q;
  logic [ROW_W-1:0]      rd_row;

  assign fits   = LVL_W'(wr_cnt) <= (LVL_W'(DEPTH) - level);
  assign do_wr  = (wr_cnt != '0) && fits;
  assign do_rd  = (level != '0);
  assign rd_row = rptr[PTR_W-1:BANK_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + PTR_W'(wr_cnt);
      if (do_rd) rptr <= rptr + PTR_W'(1);
      level <= level + (do_wr ? LVL_W'(wr_cnt) : '0) - LVL_W'(do_rd);
      if ((wr_cnt != '0) && !fits) ovf <= 1'b1;
    end
  end

  // consecutive entries fall in distinct banks, so each bank sees at most
  // one write and one read per clock
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [BANK_W-1:0] ofs;
    logic [PTR_W-1:0]  waddr;
    logic              we;
    rxu_ent_t          mem [ROWS];
    rxu_ent_t          q;

    assign ofs   = BANK_W'(b) - wptr[BANK_W-1:0];
    assign waddr = wptr + PTR_W'(ofs);
    assign we    = do_wr && (CNT_W'(ofs) < wr_cnt);

    always_ff @(posedge clk) begin
      if (we) mem[waddr[PTR_W-1:BANK_W]] <= wr_slot[ofs];
      q <= mem[rd_row];
    end
    assign bank_q[b] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= do_rd;
    sel_q <= rptr[BANK_W-1:0];
  end

  assign rd_ent = bank_q[sel_q];
endmodule

// File: rtl/rx_lane_unpacker.sv
module rx_lane_unpacker
  import rxu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        in_val,
  input  logic [LANES-1:0]        in_pay,
  input  logic [LANES-1:0]        in_fixpos,
  input  logic [LANES-1:0]        in_embpos,
  input  logic [LANES-1:0]        in_fixoh,
  input  logic [LANES-1:0]        in_emboh,
  input  logic [LANES*BYTE_W-1:0] in_data,
  output logic                    out_valid,
  output logic [BYTE_W-1:0]       out_data,
  output logic                    out_pay,
  output logic [MARK_W-1:0]       out_mark,
  output logic                    overflow
);
  logic [LANES-1:0]     cap_val;
  rxu_ent_t [LANES-1:0] cap_lane;
  rxu_ent_t [LANES-1:0] slot;
  logic [CNT_W-1:0]     slot_cnt;
  logic                 rd_valid;
  rxu_ent_t             rd_ent;
  logic [LVL_W-1:0]     fifo_level;

  rxu_capture #(.LANES(LANES)) i_capture (
    .clk(clk), .rst(rst),
    .in_val(in_val), .in_pay(in_pay),
    .in_fixpos(in_fixpos), .in_embpos(in_embpos),
    .in_fixoh(in_fixoh), .in_emboh(in_emboh),
    .in_data(in_data),
    .cap_val(cap_val), .cap_lane(cap_lane)
  );

  rxu_compact #(.LANES(LANES)) i_compact (
    .cap_val(cap_val), .cap_lane(cap_lane),
    .slot(slot), .cnt(slot_cnt)
  );

  rxu_bank_fifo #(.LANES(LANES), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst),
    .wr_cnt(slot_cnt), .wr_slot(slot),
    .rd_valid(rd_valid), .rd_ent(rd_ent),
    .level(fifo_level), .ovf(overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_pay   <= 1'b0;
      out_mark  <= '0;
    end else begin
      out_valid <= rd_valid;
      out_data  <= rd_valid ? rd_ent.data : '0;
      out_pay   <= rd_valid & rd_ent.pay;
      out_mark  <= rd_valid ? rd_ent.mark : '0;
    end
  end
endmodule

// File: rtl/rx_lane_unpacker_chk.sv
module rx_lane_unpacker_chk #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] cap_val,
  input logic [LVL_W-1:0] level,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_pay,
  input logic [3:0]       out_mark,
  input logic             overflow
);
  assert_zero_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0 && !out_pay && out_mark == '0));

  assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && !overflow && level == '0));

  assert_drain_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (level != '0) |=> ##1 out_valid);

  assert_first_byte_delay_R7: assert property (@(posedge clk) disable iff (rst)
    ((|cap_val) && level == '0) |=> ##2 out_valid);
endmodule

bind rx_lane_unpacker rx_lane_unpacker_chk #(.LANES(LANES), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .cap_val(cap_val), .level(fifo_level),
  .out_valid(out_valid), .out_data(out_data), .out_pay(out_pay),
  .out_mark(out_mark), .overflow(overflow)
);

// File: tb/test_rx_lane_unpacker.sv
module test_rx_lane_unpacker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  in_val = '0, in_pay = '0, in_fixpos = '0, in_embpos = '0;
  logic [3:0]  in_fixoh = '0, in_emboh = '0;
  logic [31:0] in_data = '0;
  logic        out_valid, out_pay, overflow;
  logic [7:0]  out_data;
  logic [3:0]  out_mark;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int zero_bad = 0;
  bit finished = 0;
  logic [12:0] exp_q[$];
  logic [12:0] got_q[$];
  int          got_t[$];

  always #4 clk = ~clk;   // 125 MHz

  rx_lane_unpacker i_rx_lane_unpacker (
    .clk(clk), .rst(rst), .in_val(in_val), .in_pay(in_pay),
    .in_fixpos(in_fixpos), .in_embpos(in_embpos), .in_fixoh(in_fixoh),
    .in_emboh(in_emboh), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_pay(out_pay), .out_mark(out_mark),
    .overflow(overflow)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      got_q.push_back({out_pay, out_mark, out_data});
      got_t.push_back(cyc);
    end
    if (!rst && !out_valid && (out_data != 0 || out_pay || out_mark != 0))
      zero_bad++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic put_word(input logic [3:0] v, p, fpos, epos, foh, eoh,
                          input logic [31:0] d, input bit expect_it);
    @(negedge clk);
    in_val = v; in_pay = p; in_fixpos = fpos; in_embpos = epos;
    in_fixoh = foh; in_emboh = eoh; in_data = d;
    if (expect_it)
      for (int l = 3; l >= 0; l--)
        if (v[l]) exp_q.push_back({p[l], fpos[l], epos[l], foh[l], eoh[l], d[8*l +: 8]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_val = '0;
      in_data = $urandom; in_pay = 4'hF; in_fixpos = 4'hF;
      in_embpos = 4'hF; in_fixoh = 4'hF; in_emboh = 4'hF;
    end
  endtask

  task automatic compare_stream(input string req);
    check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    exp_q.delete(); got_q.delete(); got_t.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); got_q.delete(); got_t.delete();
  endtask

  task automatic t_reset();
    do_reset();
    check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    check(overflow == 1'b0, "R9 overflow after reset", overflow, 0);
    check(out_data == 8'h00, "R9 out_data after reset", out_data, 0);
  endtask

  task automatic t_full_words();
    for (int w = 0; w < 4; w++)
      put_word(4'hF, 4'hF, '0, '0, '0, '0, {8'hA0 + 8'(w), 8'hB0 + 8'(w), 8'hC0 + 8'(w), 8'hD0 + 8'(w)}, 1);
    idle(30);
    check(got_t.size() == 16 && got_t[15] - got_t[0] == 15, "R6 back-to-back drain",
          got_t.size() == 16 ? got_t[15] - got_t[0] : -1, 15);
    compare_stream("R1 R6 full words lane order");
  endtask

  task automatic t_sparse();
    put_word(4'b1011, 4'hF, '0, '0, '0, '0, 32'h11223344, 1);
    put_word(4'b0101, 4'hF, '0, '0, '0, '0, 32'h55667788, 1);
    idle(2);
    put_word(4'b1000, 4'hF, '0, '0, '0, '0, 32'h99AABBCC, 1);
    put_word(4'b0001, 4'hF, '0, '0, '0, '0, 32'hDDEEFF01, 1);
    put_word(4'b0110, 4'hF, '0, '0, '0, '0, 32'h02030405, 1);
    idle(25);
    compare_stream("R2 sparse compaction");
  endtask

  task automatic t_idle_ignored();
    idle(12);
    idle(10);
    check(got_q.size() == 0, "R3 idle cycles emit nothing", got_q.size(), 0);
    put_word(4'b0010, 4'b0010, '0, '0, '0, '0, 32'h00005A00, 1);
    idle(10);
    compare_stream("R3 word after idle");
  endtask

  task automatic t_flags();
    put_word(4'hF, 4'b0101, 4'b1000, 4'b0100, 4'b0010, 4'b0001, 32'h0A0B0C0D, 1);
    put_word(4'b0110, 4'b0010, 4'b1111, 4'b1001, 4'b0100, 4'b1111, 32'hE1E2E3E4, 1);
    put_word(4'b1001, 4'b0000, 4'b0001, 4'b1000, 4'b1001, 4'b0110, 32'h31323334, 1);
    idle(25);
    check(zero_bad == 0, "R10 outputs zero when idle", zero_bad, 0);
    compare_stream("R4 R5 payload and marker flags");
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_val = 4'b0100; in_pay = 4'b0100; in_data = 32'h00770000;
    in_fixpos = '0; in_embpos = '0; in_fixoh = '0; in_emboh = '0;
    exp_q.push_back({1'b1, 4'b0000, 8'h77});
    @(posedge clk);
    @(negedge clk); in_val = '0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 not yet after two edges", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 byte after third edge", out_valid, 1);
    idle(5);
    compare_stream("R7 latency byte");
  endtask

  task automatic t_overflow();
    // occupancy rule of R8 keeps word ids 0,1,2,3,5,9 from ten back-to-back words
    for (int w = 0; w < 10; w++) begin
      bit keep;
      keep = (w <= 3) || (w == 5) || (w == 9);
      put_word(4'hF, 4'hF, '0, '0, '0, '0,
               {6'(w), 2'd3, 6'(w), 2'd2, 6'(w), 2'd1, 6'(w), 2'd0}, keep);
    end
    idle(40);
    check(overflow == 1'b1, "R8 overflow raised and held", overflow, 1);
    compare_stream("R8 whole groups kept or dropped");
    do_reset();
    check(overflow == 1'b0, "R9 reset clears overflow", overflow, 0);
    idle(5);
    check(got_q.size() == 0, "R9 FIFO empty after reset", got_q.size(), 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_words();
    t_sparse();
    t_idle_ignored();
    t_flags();
    t_latency();
    t_overflow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule